// File: doc/BRIEF.md
# Masked-Write Random Bit Collection Controller

This block gathers single random bits from an external entropy source into a 256-bit capture buffer. Software reaches it through a small register map. The control word is updated under a per-bit write mask, so one field can change without a read-modify-write. A period register sets how many clock cycles pass between two captures. The buffer is read back as eight 32-bit words.

To use it, software picks a fill length of 64, 128, 192 or 256 bits, picks an oscillator speed for the entropy source and sets the enable bit. It then sets the start bit. On every period boundary the hardware shifts one entropy bit into the buffer. It begins at word 0, bit 0, and moves upward. When the chosen number of bits is in place, the start bit drops to zero by itself. Software polls that bit as its completion flag.

Top module: `trng_collector`

## Requirements
- R1: A write to the control word at offset 0x400 changes only those bits of [15:0] whose mask bit in wdata[31:16] is 1. The control word reads back as {16'b0, ctrl[15:0]}. Its fields are: start at bit 0, enable at bit 1, speed at [3:2] and length at [5:4].
- R2: Start can only be 1 while enable is 1. A write that sets start while enable ends up 0 leaves start at 0. A write that clears enable also clears start and stops collection.
- R3: A length code n in [5:4] selects 64*(n+1) bits. The start set by a write at clock edge E reads 0 for the first time after edge E + bits*P, where P is the effective period.
- R4: The period register at offset 0x404 resets to 1000 and reads back what was written. The effective period is P = max(1, value). While start is 1 one bit is captured every P cycles, and a value of 0 captures on every cycle.
- R5: Capture number j (counting from 0) stores the entropy input, as sampled at edge E + (j+1)*P, into word j/32 at bit j%32. Bits beyond the fill length keep their previous contents.
- R6: Word i of the buffer reads at offset 0x410 + 4*i, for i = 0 to 7. The window can be read while start is 1 and then shows the bits captured so far.
- R7: The output osc_speed always equals control bits [3:2]. It changes only in the cycle after a control write.
- R8: A write of 0x0000 under the full mask (wdata 0xFFFF0000) makes the control word read 0. After that write the buffer no longer changes.
- R9: After reset the control word reads 0, the period reads 1000, every buffer word reads 0 and osc_speed is 0. An unmapped address reads 0.
- R10: Each new start, after start has been 0, fills the buffer again from word 0, bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address for reads and writes |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data; for the control word [31:16] is the bit mask |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| entropy_bit | input | 1 | Random bit from the entropy source |
| osc_speed | output | 2 | Oscillator speed setting forwarded to the entropy source |

## Verification
Register writes take effect at the edge that samples bus_we, and reads are combinational. The bench therefore drives inputs on falling edges and reads back within the same low phase. A capture lands at edge E + (j+1)*P. The start bit reads 0 at the first falling edge after edge E + bits*P. The bench counts edges with a free-running counter and derives the entropy value from that counter, so it knows which bit is sampled at which edge. It checks the exact completion cycle and every buffer bit against that schedule, and it reads the partial buffer a known number of cycles into a run.

// File: rtl/trng_pkg.sv
package trng_pkg;

    localparam int ADDR_W     = 12;
    localparam int WORD_W     = 32;
    localparam int NUM_WORDS  = 8;
    localparam int BUF_BITS   = WORD_W * NUM_WORDS;
    localparam int IDX_W      = $clog2(BUF_BITS);
    localparam int WSEL_W     = $clog2(NUM_WORDS);
    localparam int BSEL_W     = $clog2(WORD_W);
    localparam int CHUNK_BITS = 64;

    localparam logic [ADDR_W-1:0] CTRL_OFF   = 12'h400;
    localparam logic [ADDR_W-1:0] PERIOD_OFF = 12'h404;
    localparam logic [ADDR_W-1:0] DATA_OFF   = 12'h410;
    localparam logic [ADDR_W-1:0] WIN_BYTES  = ADDR_W'(NUM_WORDS * 4);

    typedef struct packed {
        logic [9:0] spare;
        logic [1:0] len_sel;
        logic [1:0] speed;
        logic       enable;
        logic       start;
    } ctrl_t;

    typedef logic [NUM_WORDS-1:0][WORD_W-1:0] buf_t;

    // Merge a masked write into the current control value.
    function automatic ctrl_t apply_mask(ctrl_t cur, logic [31:0] w);
        logic [15:0] m;
        logic [15:0] c;
        m = w[31:16];
        c = cur;
        return ctrl_t'((c & ~m) | (w[15:0] & m));
    endfunction

    // Number of bits to collect for a length code.
    function automatic logic [IDX_W:0] fill_bits(logic [1:0] sel);
        return (IDX_W+1)'((int'(sel) + 1) * CHUNK_BITS);
    endfunction

endpackage

// File: rtl/trng_ctrl_reg.sv
module trng_ctrl_reg
    import trng_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        fill_done,
    output ctrl_t       ctrl_q
);

    ctrl_t nxt;

    always_comb begin
        nxt = ctrl_q;
        if (wr_en) begin
            nxt = apply_mask(ctrl_q, wr_data);
        end
        if (fill_done) begin
            nxt.start = 1'b0;
        end
        if (!nxt.enable) begin
            nxt.start = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= nxt;
        end
    end

endmodule

// File: rtl/trng_sampler.sv
module trng_sampler #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic [PERIOD_W-1:0] period,
    output logic                tick
);

    logic [PERIOD_W-1:0] cnt;
    logic [PERIOD_W-1:0] last;

    always_comb begin
        last = (period == '0) ? '0 : period - 1'b1;
        tick = run && (cnt >= last);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/trng_shift_buf.sv
module trng_shift_buf
    import trng_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             bit_in,
    input  logic [1:0]       len_sel,
    output logic             done,
    output buf_t             words,
    output logic [IDX_W-1:0] fill_idx
);

    logic [IDX_W:0] target;

    always_comb begin
        target = fill_bits(len_sel);
        done   = tick && ({1'b0, fill_idx} == (target - 1'b1));
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            fill_idx <= '0;
        end else if (tick) begin
            fill_idx <= fill_idx + 1'b1;
        end
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [WORD_W-1:0] word_q;
        logic              hit;

        always_comb begin
            hit = tick && (fill_idx[IDX_W-1:BSEL_W] == WSEL_W'(w));
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (hit) begin
                word_q[fill_idx[BSEL_W-1:0]] <= bit_in;
            end
        end

        assign words[w] = word_q;
    end

endmodule

// File: rtl/trng_collector.sv
module trng_collector
    import trng_pkg::*;
#(
    parameter int PERIOD_W   = 16,
    parameter int PERIOD_RST = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              entropy_bit,
    output logic [1:0]        osc_speed
);

    logic                ctrl_wr;
    logic                period_wr;
    ctrl_t               ctrl_q;
    logic [PERIOD_W-1:0] period_q;
    logic                cap_tick;
    logic                fill_done;
    buf_t                buf_words;
    logic [IDX_W-1:0]    fill_idx;
    logic [ADDR_W-1:0]   win_off;
    logic                in_win;

    always_comb begin
        ctrl_wr   = bus_we && (bus_addr == CTRL_OFF);
        period_wr = bus_we && (bus_addr == PERIOD_OFF);
        osc_speed = ctrl_q.speed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= PERIOD_W'(PERIOD_RST);
        end else if (period_wr) begin
            period_q <= bus_wdata[PERIOD_W-1:0];
        end
    end

    trng_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (ctrl_wr),
        .wr_data   (bus_wdata),
        .fill_done (fill_done),
        .ctrl_q    (ctrl_q)
    );

    trng_sampler #(.PERIOD_W(PERIOD_W)) u_sampler (
        .clk    (clk),
        .rst    (rst),
        .run    (ctrl_q.start),
        .period (period_q),
        .tick   (cap_tick)
    );

    trng_shift_buf u_buf (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl_q.start),
        .tick     (cap_tick),
        .bit_in   (entropy_bit),
        .len_sel  (ctrl_q.len_sel),
        .done     (fill_done),
        .words    (buf_words),
        .fill_idx (fill_idx)
    );

    always_comb begin
        win_off   = bus_addr - DATA_OFF;
        in_win    = (bus_addr >= DATA_OFF) && (win_off < WIN_BYTES);
        bus_rdata = '0;
        if (bus_addr == CTRL_OFF) begin
            bus_rdata = {16'b0, ctrl_q};
        end else if (bus_addr == PERIOD_OFF) begin
            bus_rdata = 32'(period_q);
        end else if (in_win) begin
            bus_rdata = buf_words[win_off[BSEL_W-1:2]];
        end
    end

endmodule

// File: rtl/trng_chk.sv
module trng_chk #(
    parameter int PERIOD_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                ctrl_wr,
    input logic [31:0]         wr_data,
    input logic [15:0]         ctrl_bits,
    input logic [1:0]          speed_out,
    input logic                tick,
    input logic [PERIOD_W-1:0] period_val
);

    // R2
    start_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_bits[0]) |-> $past(ctrl_wr));

    // R7
    speed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(ctrl_wr) |-> $stable(speed_out));

    // R4
    capture_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && $past(tick)) |-> (period_val <= 1));

    // R4
    tick_run_chk: assert property (@(posedge clk) disable iff (rst)
        tick |-> ctrl_bits[0]);

    // R3
    done_fall_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(ctrl_bits[0]) && !$past(ctrl_wr)) |-> $past(tick));

    // R8
    stop_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wr_data == 32'hFFFF_0000) |=> (ctrl_bits == 16'h0000));

endmodule

bind trng_collector trng_chk #(.PERIOD_W(PERIOD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctrl_wr    (ctrl_wr),
    .wr_data    (bus_wdata),
    .ctrl_bits  (ctrl_q),
    .speed_out  (osc_speed),
    .tick       (cap_tick),
    .period_val (period_q)
);

// File: tb/test_trng_collector.sv
module test_trng_collector;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        entropy_bit;
    logic [1:0]  osc_speed;

    int unsigned cyc = 0;
    int          n_checks = 0;
    int          n_errors = 0;
    int unsigned last_wr_cyc;
    logic [31:0] exp_w [8];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic ent(input int unsigned c);
        logic [31:0] h;
        h = c * 32'h9E37_79B1;
        return h[17] ^ h[29];
    endfunction

    assign entropy_bit = ent(cyc);

    trng_collector i_trng_collector (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (bus_addr),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .entropy_bit (entropy_bit),
        .osc_speed   (osc_speed)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr    = a;
        bus_wdata   = d;
        bus_we      = 1'b1;
        last_wr_cyc = cyc;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check_words(input string tag);
        logic [31:0] v;
        for (int i = 0; i < 8; i++) begin
            rd(12'h410 + 12'(4*i), v);
            check(v === exp_w[i], tag, v, exp_w[i]);
        end
    endtask

    // One complete collection run with length code len and period value per.
    task automatic run_fill(input int len, input int per, input int spd);
        int unsigned c0;
        int          eff;
        int          nbits;
        int unsigned elapsed;
        logic [31:0] v;
        bit          hung;
        eff   = (per == 0) ? 1 : per;
        nbits = 64 * (len + 1);
        wr(12'h404, 32'(per));
        wr(12'h400, 32'h003F_0000 | 32'(len << 4) | 32'(spd << 2) | 32'h3);
        c0 = last_wr_cyc;
        // R7: speed output follows the control field
        check(osc_speed == 2'(spd), "R7 osc_speed", 32'(osc_speed), 32'(spd));
        hung = 1'b0;
        for (int k = 0; k < 20000; k++) begin
            rd(12'h400, v);
            if (!v[0]) break;
            @(negedge clk);
            if (k == 19999) hung = 1'b1;
        end
        elapsed = cyc - c0 - 1;
        // R3: completion cycle is bits * effective period after the write edge
        check(!hung && elapsed == 32'(nbits * eff), "R3 fill duration",
              elapsed, 32'(nbits * eff));
        // R10/R5: bits land from bit 0 upward; higher words untouched
        for (int j = 0; j < nbits; j++) begin
            exp_w[j / 32][j % 32] = ent(c0 + 32'((j + 1) * eff));
        end
        check_words("R5 R10 buffer content");
    endtask

    always @(posedge clk) begin
        if (cyc > WATCHDOG) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int unsigned c0;
        rst       = 1'b1;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        for (int i = 0; i < 8; i++) exp_w[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: reset state
        rd(12'h400, v);  check(v == 32'h0, "R9 ctrl reset", v, 32'h0);
        rd(12'h404, v);  check(v == 32'd1000, "R9 period reset", v, 32'd1000);
        rd(12'h008, v);  check(v == 32'h0, "R9 unmapped read", v, 32'h0);
        check(osc_speed == 2'b00, "R9 osc_speed reset", 32'(osc_speed), 32'h0);
        check_words("R9 buffer reset");

        // R1: only masked bits change
        wr(12'h400, 32'h000C_003F);
        rd(12'h400, v);  check(v == 32'h000C, "R1 masked speed write", v, 32'h000C);
        check(osc_speed == 2'b11, "R7 speed after write", 32'(osc_speed), 32'h3);
        // R2: start while enable is 0 is ignored
        wr(12'h400, 32'h0001_0001);
        rd(12'h400, v);  check(v == 32'h000C, "R2 start ignored", v, 32'h000C);
        wr(12'h400, 32'h0002_0002);
        rd(12'h400, v);  check(v == 32'h000E, "R1 enable set", v, 32'h000E);
        wr(12'h400, 32'h000C_0000);
        rd(12'h400, v);  check(v == 32'h0002, "R1 speed cleared", v, 32'h0002);

        // R4: period readback
        wr(12'h404, 32'd5);
        rd(12'h404, v);  check(v == 32'd5, "R4 period readback", v, 32'd5);

        // R2: clearing enable stops a run before its first capture
        wr(12'h404, 32'd3);
        wr(12'h400, 32'h003F_0003);
        wr(12'h400, 32'h0002_0000);
        rd(12'h400, v);  check(v == 32'h0, "R2 enable clear drops start", v, 32'h0);
        repeat (10) @(negedge clk);
        check_words("R2 no capture after disable");

        // R6: partial read during a run, then R8 stop
        wr(12'h404, 32'd4);
        wr(12'h400, 32'h003F_0003);
        c0 = last_wr_cyc;
        repeat (40) @(negedge clk);
        for (int j = 0; j < 10; j++) exp_w[0][j] = ent(c0 + 32'((j + 1) * 4));
        rd(12'h400, v);  check(v[0] == 1'b1, "R6 start still set", v, 32'h3);
        rd(12'h410, v);  check(v === exp_w[0], "R6 partial word0", v, exp_w[0]);
        wr(12'h400, 32'hFFFF_0000);
        rd(12'h400, v);  check(v == 32'h0, "R8 stop clears ctrl", v, 32'h0);
        repeat (20) @(negedge clk);
        check_words("R8 buffer frozen after stop");

        // Sweep every length code over several periods (R3 R4 R5 R10)
        for (int len = 0; len < 4; len++) begin
            for (int pi = 0; pi < 3; pi++) begin
                int per;
                per = (pi == 0) ? 0 : ((pi == 1) ? 1 : 3);
                run_fill(len, per, (len + pi) % 4);
            end
        end
        // Shorter fill after a full one leaves the upper words intact (R5)
        run_fill(0, 2, 1);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule